// File: doc/BRIEF.md
# Two-State 16-Bit External Bus Controller

This block turns byte and word read or write requests from the internal side into cycles on an external 16-bit memory bus. Every external cycle lasts two clocks, a first state and a second state, and never stretches. During those two clocks the block drives the address, pulls down one of eight chip selects, and drives the address strobe together with either the read strobe or one or both of the lane write strobes.

The bus is big-endian. A byte at an even address travels on the upper data lane (bits 15..8), and a byte at an odd address travels on the lower lane (bits 7..0). A word uses both lanes, with the even byte on the upper lane. The external data pins are split into an output vector, a per-lane drive enable and an input vector, so that the pad ring can build the three-state buffers. A lane whose enable is low is not driven (high impedance).

The internal side uses a valid/acknowledge handshake. The requester holds `req_valid` and the request fields steady until it sees `req_ack`. The acknowledge is high for exactly the second-state clock, and read data is valid in that same clock.

Top module: `ebc16_2state`

## Requirements
- R1: Once the block is idle and `req_valid` is high at a rising edge, the next clock is the first state and the clock after that is the second state. `bus_as_n` is low in exactly these two clocks and high in the clock that follows.
- R2: `req_ack` is high only in the second-state clock. If `req_valid` is still high in the idle clock after an acknowledge, that new request starts its first state on the next edge.
- R3: `wait_n` has no effect: a cycle with `wait_n` held low still acknowledges in its second clock.
- R4: The chip-select index is the top three address bits (`addr[ADDR_W-1:ADDR_W-3]`). `bus_cs_n[index]` is low during both states, and every other chip select stays high.
- R5: For a byte write to an even address, `bus_hwr_n` is low and `bus_lwr_n` is high. Only the upper lane is driven (`bus_doe` = 2'b10), and `bus_dout[15:8]` equals `req_wdata[7:0]`.
- R6: For a byte write to an odd address, `bus_lwr_n` is low and `bus_hwr_n` is high. Only the lower lane is driven (`bus_doe` = 2'b01), and `bus_dout[7:0]` equals `req_wdata[7:0]`.
- R7: A byte read at an even address holds `bus_rd_n` low in both states and drives no lane. It returns `req_rdata` = {8'h00, `bus_din[15:8]`}, and the lower lane is ignored.
- R8: A byte read at an odd address returns `req_rdata` = {8'h00, `bus_din[7:0]`}.
- R9: A word write pulls both write strobes low, drives both lanes (`bus_doe` = 2'b11) and puts `req_wdata` unchanged on `bus_dout`. A word read returns `bus_din` unchanged.
- R10: A word request with an odd address is carried out at the even address below it: address bit 0 is driven as 0.
- R11: In reset and when idle, every strobe and chip select is high, `bus_doe` is 0, `bus_addr` is 0 and `req_ack` is low.
- R12: `bus_addr` carries the latched request address, unchanged, through both states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7..0 |
| wait_n | input | 1 | Wait request from the bus; ignored in this space |
| req_ack | output | 1 | High in the second state; the transfer is complete |
| req_rdata | output | 16 | Read data, valid while `req_ack` is high |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | NUM_CS | Active-low chip selects |
| bus_as_n | output | 1 | Active-low address strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_hwr_n | output | 1 | Active-low upper-lane write strobe |
| bus_lwr_n | output | 1 | Active-low lower-lane write strobe |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_doe | output | 2 | Lane drive enables (bit 1 upper, bit 0 lower) |
| bus_din | input | 16 | Data read from the bus |

## Verification
The bench builds the block with `ADDR_W` = 16 and keeps the default eight chip selects. Each chip-select region is then 8 KiB, so short 16-bit addresses reach all eight regions, including the highest one at 16'hE000 and above. With these values, every region, both byte parities, word alignment and the ignored wait input can be exercised in a short vector table.

// File: rtl/ebc16_pkg.sv
package ebc16_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_T1   = 2'd1,
      ST_T2   = 2'd2
   } bus_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/ebc16_seq.sv
// Two-state cycle sequencer: idle -> first state -> second state -> idle.
module ebc16_seq
   import ebc16_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   output logic accept,
   output logic in_cycle,
   output logic in_t2
);
   bus_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: st_d = req_valid ? ST_T1 : ST_IDLE;
         ST_T1:   st_d = ST_T2;
         ST_T2:   st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign accept   = (st_q == ST_IDLE) && req_valid;
   assign in_cycle = (st_q == ST_T1) || (st_q == ST_T2);
   assign in_t2    = (st_q == ST_T2);
endmodule

// File: rtl/ebc16_cs_decode.sv
// One fixed address region per chip select, picked by the top address bits.
module ebc16_cs_decode #(
   parameter int ADDR_W = 24,
   parameter int NUM_CS = 8
) (
   input  logic              active,
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CS-1:0] cs_n
);
   localparam int SEL_W = $clog2(NUM_CS);

   logic [SEL_W-1:0] sel;
   assign sel = addr[ADDR_W-1 -: SEL_W];

   wire unused_low_addr = ^addr[ADDR_W-SEL_W-1:0];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(active && (sel == SEL_W'(i)));
   end
endmodule

// File: rtl/ebc16_lane_steer.sv
// Big-endian byte-lane steering: strobes, write lanes and read capture.
module ebc16_lane_steer
   import ebc16_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                       active,
   input  logic                       in_t2,
   input  logic                       wr,
   input  logic                       word,
   input  logic                       a0,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [DATA_W-1:0]          din,
   output logic                       rd_n,
   output logic                       hwr_n,
   output logic                       lwr_n,
   output logic [DATA_W-1:0]          dout,
   output logic [DATA_W/BYTE_W-1:0]   doe,
   output logic [DATA_W-1:0]          rdata
);
   localparam int LANES = DATA_W / BYTE_W;

   logic [LANES-1:0]  lane_hit;
   logic [BYTE_W-1:0] rd_byte;

   // lane k carries byte offset LANES-1-k (upper lane = even byte)
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic LANE_OFS = 1'((LANES - 1 - k) % 2);
      assign lane_hit[k] = word || (a0 == LANE_OFS);
      assign doe[k]      = active && wr && lane_hit[k];
      assign dout[k*BYTE_W +: BYTE_W] =
         !doe[k] ? '0 : (word ? wdata[k*BYTE_W +: BYTE_W] : wdata[BYTE_W-1:0]);
   end

   assign hwr_n = !doe[LANES-1];
   assign lwr_n = !doe[0];
   assign rd_n  = !(active && !wr);

   assign rd_byte = a0 ? din[BYTE_W-1:0] : din[DATA_W-1 -: BYTE_W];

   always_comb begin
      rdata = '0;
      if (in_t2 && !wr) begin
         if (word) rdata = din;
         else      rdata = {{(DATA_W-BYTE_W){1'b0}}, rd_byte};
      end
   end
endmodule

// File: rtl/ebc16_2state.sv
// Top: request latch, sequencer, chip-select decode and lane steering.
module ebc16_2state
   import ebc16_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int NUM_CS = 8,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic                     req_word,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     wait_n,
   output logic                     req_ack,
   output logic [DATA_W-1:0]        req_rdata,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [NUM_CS-1:0]        bus_cs_n,
   output logic                     bus_as_n,
   output logic                     bus_rd_n,
   output logic                     bus_hwr_n,
   output logic                     bus_lwr_n,
   output logic [DATA_W-1:0]        bus_dout,
   output logic [DATA_W/BYTE_W-1:0] bus_doe,
   input  logic [DATA_W-1:0]        bus_din
);
   localparam int SEL_W = $clog2(NUM_CS);

   if (DATA_W != 16) begin : g_bad_width
      $error("ebc16_2state: DATA_W must be 16");
   end
   if (NUM_CS < 2 || (1 << SEL_W) != NUM_CS) begin : g_bad_cs
      $error("ebc16_2state: NUM_CS must be a power of two, at least 2");
   end
   if (ADDR_W <= SEL_W + 1) begin : g_bad_addr
      $error("ebc16_2state: ADDR_W too small for the chip-select field");
   end

   // this space never inserts wait states
   wire unused_wait_n = wait_n;

   logic              accept, in_cycle, in_t2;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q, word_q;

   ebc16_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .accept    (accept),
      .in_cycle  (in_cycle),
      .in_t2     (in_t2)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         word_q  <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
         word_q  <= req_word;
      end
   end

   ebc16_cs_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CS (NUM_CS)
   ) u_cs (
      .active (in_cycle),
      .addr   (addr_q),
      .cs_n   (bus_cs_n)
   );

   ebc16_lane_steer #(
      .DATA_W (DATA_W)
   ) u_lanes (
      .active (in_cycle),
      .in_t2  (in_t2),
      .wr     (wr_q),
      .word   (word_q),
      .a0     (addr_q[0]),
      .wdata  (wdata_q),
      .din    (bus_din),
      .rd_n   (bus_rd_n),
      .hwr_n  (bus_hwr_n),
      .lwr_n  (bus_lwr_n),
      .dout   (bus_dout),
      .doe    (bus_doe),
      .rdata  (req_rdata)
   );

   assign bus_addr = in_cycle ? addr_q : '0;
   assign bus_as_n = !in_cycle;
   assign req_ack  = in_t2;
endmodule

// File: rtl/ebc16_2state_chk.sv
module ebc16_2state_chk #(
   parameter int ADDR_W = 24,
   parameter int NUM_CS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NUM_CS-1:0] bus_cs_n,
   input logic              bus_as_n,
   input logic              bus_rd_n,
   input logic              bus_hwr_n,
   input logic              bus_lwr_n,
   input logic [1:0]        bus_doe
);
   assert_second_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_as_n) |=> !bus_as_n);

   assert_cycle_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && !$past(bus_as_n)) |=> bus_as_n);

   assert_ack_in_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (!bus_as_n && !$past(bus_as_n)));

   assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   assert_cs_with_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_as_n == (&bus_cs_n));

   assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (bus_hwr_n && bus_lwr_n && bus_doe == 2'b00));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_as_n |-> (bus_rd_n && bus_hwr_n && bus_lwr_n && bus_doe == 2'b00 && !req_ack));

   assert_addr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && !$past(bus_as_n)) |-> $stable(bus_addr));
endmodule

bind ebc16_2state ebc16_2state_chk #(
   .ADDR_W (ADDR_W),
   .NUM_CS (NUM_CS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ack   (req_ack),
   .bus_addr  (bus_addr),
   .bus_cs_n  (bus_cs_n),
   .bus_as_n  (bus_as_n),
   .bus_rd_n  (bus_rd_n),
   .bus_hwr_n (bus_hwr_n),
   .bus_lwr_n (bus_lwr_n),
   .bus_doe   (bus_doe)
);

// File: tb/ebc16_2state_bench.sv
module ebc16_2state_bench;
   localparam int AW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        wait_n = 1'b1;
   logic        req_ack;
   logic [15:0] req_rdata;
   logic [AW-1:0] bus_addr;
   logic [7:0]  bus_cs_n;
   logic        bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n;
   logic [15:0] bus_dout;
   logic [1:0]  bus_doe;
   logic [15:0] bus_din = '0;

   int n_checks = 0;
   int n_errs   = 0;

   always #10 clk = ~clk;

   ebc16_2state #(.ADDR_W(AW)) u_ebc16_2state (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .wait_n(wait_n), .req_ack(req_ack), .req_rdata(req_rdata),
      .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_as_n(bus_as_n),
      .bus_rd_n(bus_rd_n), .bus_hwr_n(bus_hwr_n), .bus_lwr_n(bus_lwr_n),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
   );

   // {write, word, wait_low, addr, wdata, din, expected rdata}
   localparam int VW = 67;
   localparam int NV = 9;
   localparam logic [VW-1:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 1'b0, 16'h0010, 16'h0000, 16'hA55A, 16'h00A5},
      {1'b0, 1'b0, 1'b0, 16'h2011, 16'h0000, 16'hA55A, 16'h005A},
      {1'b1, 1'b0, 1'b0, 16'h4020, 16'hFFC3, 16'h0000, 16'h0000},
      {1'b1, 1'b0, 1'b0, 16'h6021, 16'hEE3C, 16'h0000, 16'h0000},
      {1'b0, 1'b1, 1'b0, 16'h8000, 16'h0000, 16'h1234, 16'h1234},
      {1'b1, 1'b1, 1'b0, 16'hA002, 16'hBEEF, 16'h0000, 16'h0000},
      {1'b0, 1'b1, 1'b0, 16'hC007, 16'h0000, 16'h5678, 16'h5678},
      {1'b0, 1'b0, 1'b1, 16'hE0FF, 16'h0000, 16'h9A0B, 16'h000B},
      {1'b1, 1'b0, 1'b1, 16'hFFFE, 16'h1177, 16'h0000, 16'h0000}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check(bus_as_n === 1'b1, {tag, " R11 as_n"}, 32'(bus_as_n), 1);
      check(bus_cs_n === 8'hFF, {tag, " R11 cs_n"}, 32'(bus_cs_n), 32'hFF);
      check({bus_rd_n, bus_hwr_n, bus_lwr_n} === 3'b111, {tag, " R11 strobes"},
            32'({bus_rd_n, bus_hwr_n, bus_lwr_n}), 7);
      check(bus_doe === 2'b00, {tag, " R11 doe"}, 32'(bus_doe), 0);
      check(bus_addr === '0, {tag, " R11 addr"}, 32'(bus_addr), 0);
      check(req_ack === 1'b0, {tag, " R11 ack"}, 32'(req_ack), 0);
   endtask

   // strobe/lane checks shared by both states of one access
   task automatic check_bus(input logic wr, word, input logic [15:0] ea,
                            input logic [15:0] wd);
      logic up, lo;
      logic [15:0] exp_dout;
      up = word || !ea[0];
      lo = word || ea[0];
      exp_dout = '0;
      if (wr && up) exp_dout[15:8] = word ? wd[15:8] : wd[7:0];
      if (wr && lo) exp_dout[7:0]  = wd[7:0];
      check(bus_as_n === 1'b0, "R1 as_n low", 32'(bus_as_n), 0);
      check(bus_cs_n === ~(8'h01 << ea[15:13]), "R4 cs_n", 32'(bus_cs_n),
            32'(~(8'h01 << ea[15:13])));
      check(bus_addr === ea, "R12 R10 addr", 32'(bus_addr), 32'(ea));
      check(bus_rd_n === wr, "R7 rd_n", 32'(bus_rd_n), 32'(wr));
      check(bus_hwr_n === !(wr && up), "R5 R9 hwr_n", 32'(bus_hwr_n), 32'(!(wr && up)));
      check(bus_lwr_n === !(wr && lo), "R6 R9 lwr_n", 32'(bus_lwr_n), 32'(!(wr && lo)));
      check(bus_doe === (wr ? {up, lo} : 2'b00), "R5 R6 R9 doe", 32'(bus_doe),
            32'(wr ? {up, lo} : 2'b00));
      check(bus_dout === exp_dout, "R5 R6 R9 dout", 32'(bus_dout), 32'(exp_dout));
   endtask

   task automatic run_access(input logic [VW-1:0] v);
      logic wr, word, wt;
      logic [15:0] a, wd, din, exp, ea;
      {wr, word, wt, a, wd, din, exp} = v;
      ea = word ? {a[15:1], 1'b0} : a;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a;
      req_wdata = wd; bus_din = din; wait_n = !wt;
      @(negedge clk);                       // first state
      check_bus(wr, word, ea, wd);
      check(req_ack === 1'b0, "R2 no ack in first state", 32'(req_ack), 0);
      @(negedge clk);                       // second state
      check_bus(wr, word, ea, wd);
      check(req_ack === 1'b1, wt ? "R3 ack despite wait" : "R2 ack", 32'(req_ack), 1);
      if (!wr)
         check(req_rdata === exp, word ? "R9 word rdata" :
               (ea[0] ? "R8 odd rdata" : "R7 even rdata"), 32'(req_rdata), 32'(exp));
      req_valid = 1'b0; wait_n = 1'b1;
      @(negedge clk);                       // back to idle
      check_idle("after access R1");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("idle after reset");

      for (int i = 0; i < NV; i++) run_access(VEC[i]);

      // R7: lower lane garbage must not leak into an even byte read
      run_access({1'b0, 1'b0, 1'b0, 16'h0100, 16'h0000, 16'h3CFF, 16'h003C});

      // R2: back-to-back request held through the idle clock
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0;
      req_addr = 16'h2000; bus_din = 16'h4455;
      @(negedge clk);
      @(negedge clk);
      check(req_ack === 1'b1, "R2 first ack", 32'(req_ack), 1);
      req_addr = 16'h4001;
      @(negedge clk);
      check(bus_as_n === 1'b1, "R2 idle gap", 32'(bus_as_n), 1);
      @(negedge clk);
      check(bus_as_n === 1'b0, "R2 next first state", 32'(bus_as_n), 0);
      check(bus_cs_n === 8'hFB, "R2 R4 next cs", 32'(bus_cs_n), 32'hFB);
      @(negedge clk);
      check(req_rdata === 16'h0055, "R2 R8 second rdata", 32'(req_rdata), 32'h55);
      req_valid = 1'b0;
      @(negedge clk);
      check_idle("after back-to-back R2");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule